// File: doc/BRIEF.md
# Wavefront Lane Mask Sequencer

This block keeps track of which lanes of a 64-lane wavefront may execute while structured branches and loops are running. A compare unit delivers one condition bit per lane as a ready vector. A sequencer issues flow commands: open a branch, switch to its other side, close it, open a loop, test for another iteration, close the loop, and launch a new wavefront. The block holds the resulting active-lane mask. It also feeds one 16-lane slice of that mask per cycle to a 16-wide datapath, which covers the full wavefront in four cycles.

Nesting uses a last-in first-out stack of enclosing masks with a parameterized depth. The default depth is 8. When a branch side has no lanes left, the block raises a one-cycle skip strobe, so the sequencer can jump over that path. After a loop test, it reports whether any lane still needs another pass. The wavefront therefore stays in the loop until its slowest lane leaves. A stack misuse sets a sticky error flag. A launch sets the mask to the first n lanes, so a partial tail wavefront starts with its unused lanes off. Lane i of wavefront k stands for global item k*64+i.

Top module: `simdMaskUnit`

## Requirements
- R1: After reset, all 64 lanes are active, the stack depth is 0, errFlag, skipPath and loopAgain are low, and groupIdx is 0.
- R2: groupIdx advances by one every clock and wraps from 3 to 0. groupMask always equals lanes 16*groupIdx to 16*groupIdx+15 of activeMask.
- R3: A command is taken when cmdValid is high. Op code 1 (branch open) pushes the current mask and sets the mask to the current mask AND condBits. Both changes are visible on the next cycle.
- R4: Op code 2 (other side) sets the mask to the stack top AND NOT the current mask, and leaves the stack as it is.
- R5: Op code 3 (branch close) restores the mask from the stack top and pops it.
- R6: skipPath is high for exactly the one cycle after an op 1 or op 2 whose new mask is all zero. It is low otherwise.
- R7: Op code 4 (loop open) pushes the mask without changing it. Op code 5 (loop test) ANDs the mask with condBits, and loopAgain is high for one cycle if any lane remains. Op code 6 (loop close) pops and restores the mask. The number of passes equals the largest per-lane iteration count.
- R8: A push (op 1 or 4) at depth 8 sets errFlag and leaves the mask and the stack unchanged.
- R9: Op 2, 3 or 6 at depth 0 sets errFlag and leaves the mask unchanged. errFlag stays high until reset, even across a launch.
- R10: Op code 7 (launch) empties the stack and activates lanes 0 to launchCount-1. A count of 64 or more activates all lanes.
- R11: With cmdValid low, or with op code 0, activeMask and the stack depth do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 3 | Command code (0 none, 1 branch open, 2 other side, 3 branch close, 4 loop open, 5 loop test, 6 loop close, 7 launch) |
| condBits | input | 64 | Per-lane condition from the compare unit |
| launchCount | input | 7 | Number of valid lanes for a launch |
| activeMask | output | 64 | Current active-lane mask |
| groupMask | output | 16 | Mask slice for the lane group issued this cycle |
| groupIdx | output | 2 | Lane group issued this cycle |
| skipPath | output | 1 | The path just entered has no active lanes |
| loopAgain | output | 1 | At least one lane continues after a loop test |
| stackDepth | output | 4 | Number of saved masks |
| errFlag | output | 1 | Sticky stack misuse flag |

## Verification
The bench uses the default build: 64 lanes, 16-lane groups and a stack of 8. With a stack of 8, both full-depth nesting and the overflow edge are reached in a few commands. Every launch count from 0 to 70 is swept, and each result is compared with all four group slices. Random condition vectors drive nested branches down to the full depth. A loop with per-lane trip counts from 0 to 6 confirms that the number of passes follows the slowest lane.

// File: rtl/simd_mask_pkg.sv
package simd_mask_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_IF     = 3'd1,
    OP_ELSE   = 3'd2,
    OP_ENDIF  = 3'd3,
    OP_LBEGIN = 3'd4,
    OP_LTEST  = 3'd5,
    OP_LEND   = 3'd6,
    OP_LAUNCH = 3'd7
  } maskOp_e;

  typedef enum logic [2:0] {
    LD_HOLD, LD_IF, LD_ELSE, LD_TEST, LD_POP, LD_LAUNCH
  } maskLoad_e;

  typedef struct packed {
    logic      push;
    logic      pop;
    logic      flagSkip;
    maskLoad_e load;
  } maskStrobe_t;
endpackage

// File: rtl/maskCtrl.sv
module maskCtrl
  import simd_mask_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  maskOp_e       cmdOp,
  output maskStrobe_t   strobe,
  output logic [DW-1:0] depth,
  output logic          errFlag
);
  logic isFull, isEmpty, misuse;

  assign isFull  = (depth == DW'(DEPTH));
  assign isEmpty = (depth == '0);

  always_comb begin
    strobe = '{push: 1'b0, pop: 1'b0, flagSkip: 1'b0, load: LD_HOLD};
    misuse = 1'b0;
    if (cmdValid) begin
      unique case (cmdOp)
        OP_IF: begin
          if (isFull) misuse = 1'b1;
          else begin
            strobe.push = 1'b1;
            strobe.load = LD_IF;
            strobe.flagSkip = 1'b1;
          end
        end
        OP_LBEGIN: begin
          if (isFull) misuse = 1'b1;
          else strobe.push = 1'b1;
        end
        OP_ELSE: begin
          if (isEmpty) misuse = 1'b1;
          else begin
            strobe.load = LD_ELSE;
            strobe.flagSkip = 1'b1;
          end
        end
        OP_ENDIF, OP_LEND: begin
          if (isEmpty) misuse = 1'b1;
          else begin
            strobe.pop = 1'b1;
            strobe.load = LD_POP;
          end
        end
        OP_LTEST:  strobe.load = LD_TEST;
        OP_LAUNCH: strobe.load = LD_LAUNCH;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depth   <= '0;
      errFlag <= 1'b0;
    end else begin
      if (misuse) errFlag <= 1'b1;
      if (strobe.load == LD_LAUNCH) depth <= '0;
      else if (strobe.push) depth <= depth + 1'b1;
      else if (strobe.pop) depth <= depth - 1'b1;
    end
  end
endmodule

// File: rtl/maskPath.sv
module maskPath
  import simd_mask_pkg::*;
#(
  parameter int LANES = 64,
  parameter int GROUP = 16,
  parameter int DEPTH = 8,
  localparam int DW = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(LANES + 1),
  localparam int GROUPS = LANES / GROUP,
  localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  maskStrobe_t      strobe,
  input  logic [DW-1:0]    depth,
  input  logic [LANES-1:0] condBits,
  input  logic [CW-1:0]    launchCount,
  output logic [LANES-1:0] activeMask,
  output logic [GROUP-1:0] groupMask,
  output logic [GW-1:0]    groupIdx,
  output logic             skipPath,
  output logic             loopAgain
);
  logic [LANES-1:0] stackMem [DEPTH];
  logic [LANES-1:0] topMask, nextMask, launchMask;
  logic [DW-1:0]    topPtr;

  assign topPtr  = depth - 1'b1;
  assign topMask = (depth == '0) ? '0 : stackMem[AW'(topPtr)];

  for (genvar i = 0; i < LANES; i++) begin : gLaunch
    assign launchMask[i] = (CW'(i) < launchCount);
  end

  always_comb begin
    unique case (strobe.load)
      LD_IF:     nextMask = activeMask & condBits;
      LD_ELSE:   nextMask = topMask & ~activeMask;
      LD_TEST:   nextMask = activeMask & condBits;
      LD_POP:    nextMask = topMask;
      LD_LAUNCH: nextMask = launchMask;
      default:   nextMask = activeMask;
    endcase
  end

  always_ff @(posedge clk) begin
    if (strobe.push) stackMem[AW'(depth)] <= activeMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeMask <= '1;
      skipPath   <= 1'b0;
      loopAgain  <= 1'b0;
      groupIdx   <= '0;
    end else begin
      activeMask <= nextMask;
      skipPath   <= strobe.flagSkip && (nextMask == '0);
      loopAgain  <= (strobe.load == LD_TEST) && (nextMask != '0);
      groupIdx   <= groupIdx + 1'b1;
    end
  end

  assign groupMask = activeMask[groupIdx*GROUP +: GROUP];
endmodule

// File: rtl/simdMaskUnit.sv
module simdMaskUnit
  import simd_mask_pkg::*;
#(
  parameter int LANES = 64,
  parameter int GROUP = 16,
  parameter int DEPTH = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            cmdValid,
  input  logic [2:0]                      cmdOp,
  input  logic [LANES-1:0]                condBits,
  input  logic [$clog2(LANES+1)-1:0]      launchCount,
  output logic [LANES-1:0]                activeMask,
  output logic [GROUP-1:0]                groupMask,
  output logic [$clog2(LANES/GROUP)-1:0]  groupIdx,
  output logic                            skipPath,
  output logic                            loopAgain,
  output logic [$clog2(DEPTH+1)-1:0]      stackDepth,
  output logic                            errFlag
);
  maskStrobe_t strobe;

  maskCtrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(maskOp_e'(cmdOp)),
    .strobe(strobe), .depth(stackDepth), .errFlag(errFlag)
  );

  maskPath #(.LANES(LANES), .GROUP(GROUP), .DEPTH(DEPTH)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .depth(stackDepth),
    .condBits(condBits), .launchCount(launchCount),
    .activeMask(activeMask), .groupMask(groupMask), .groupIdx(groupIdx),
    .skipPath(skipPath), .loopAgain(loopAgain)
  );
endmodule

// File: rtl/maskUnitChecker.sv
module maskUnitChecker #(
  parameter int LANES = 64,
  parameter int GROUPS = 4,
  parameter int DEPTH = 8
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         cmdValid,
  input logic [2:0]                   cmdOp,
  input logic [LANES-1:0]             activeMask,
  input logic [$clog2(GROUPS)-1:0]    groupIdx,
  input logic                         skipPath,
  input logic [$clog2(DEPTH+1)-1:0]   stackDepth,
  input logic                         errFlag
);
  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    stackDepth <= ($clog2(DEPTH+1))'(DEPTH)); // R8

  AST_SKIP_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    skipPath |-> (activeMask == '0)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdValid || cmdOp == 3'd0) |=> ($stable(activeMask) && $stable(stackDepth))); // R11

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag); // R9

  AST_GROUP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (groupIdx == ($clog2(GROUPS))'($past(groupIdx) + 1'b1))); // R2

  AST_IF_NARROWS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 3'd1 && stackDepth < ($clog2(DEPTH+1))'(DEPTH))
    |=> ((activeMask & ~$past(activeMask)) == '0)); // R3
endmodule

bind simdMaskUnit maskUnitChecker #(.LANES(LANES), .GROUPS(LANES/GROUP), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .activeMask(activeMask), .groupIdx(groupIdx), .skipPath(skipPath),
  .stackDepth(stackDepth), .errFlag(errFlag)
);

// File: tb/simdMaskUnit_bench.sv
module simdMaskUnit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = 3'd0;
  logic [63:0] condBits = '0;
  logic [6:0]  launchCount = '0;
  logic [63:0] activeMask;
  logic [15:0] groupMask;
  logic [1:0]  groupIdx;
  logic        skipPath, loopAgain, errFlag;
  logic [3:0]  stackDepth;

  int checks = 0;
  int fails = 0;

  logic [63:0] mMask;
  logic [63:0] mStk [8];
  int          mDep;
  logic        mErr, mSkip, mLoop;

  simdMaskUnit u_simdMaskUnit (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .condBits(condBits), .launchCount(launchCount), .activeMask(activeMask),
    .groupMask(groupMask), .groupIdx(groupIdx), .skipPath(skipPath),
    .loopAgain(loopAgain), .stackDepth(stackDepth), .errFlag(errFlag)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkState(input string tag);
    check(activeMask == mMask, {tag, " mask"}, activeMask, mMask);
    check(stackDepth == 4'(mDep), {tag, " depth"}, 64'(stackDepth), 64'(mDep));
    check(errFlag == mErr, {tag, " err"}, 64'(errFlag), 64'(mErr));
    check(skipPath == mSkip, {tag, " skip R6"}, 64'(skipPath), 64'(mSkip));
    check(loopAgain == mLoop, {tag, " loop"}, 64'(loopAgain), 64'(mLoop));
  endtask

  function automatic logic [63:0] firstLanes(input int n);
    return (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    cmdValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mMask = '1; mDep = 0; mErr = 1'b0; mSkip = 1'b0; mLoop = 1'b0;
  endtask

  task automatic issue(input int op, input logic [63:0] cond, input int cnt, input string tag);
    cmdOp = 3'(op); condBits = cond; launchCount = 7'(cnt); cmdValid = 1'b1;
    mSkip = 1'b0; mLoop = 1'b0;
    case (op)
      1, 4: if (mDep == 8) mErr = 1'b1;
            else begin
              mStk[mDep] = mMask; mDep++;
              if (op == 1) begin mMask = mMask & cond; mSkip = (mMask == '0); end
            end
      2: if (mDep == 0) mErr = 1'b1;
         else begin mMask = mStk[mDep-1] & ~mMask; mSkip = (mMask == '0); end
      3, 6: if (mDep == 0) mErr = 1'b1;
            else begin mDep--; mMask = mStk[mDep]; end
      5: begin mMask = mMask & cond; mLoop = (mMask != '0); end
      7: begin mDep = 0; mMask = firstLanes(cnt); end
      default: ;
    endcase
    @(negedge clk);
    cmdValid = 1'b0;
    checkState(tag);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state, sampled before the first clock after release
    check(groupIdx == 2'd0, "R1 groupIdx", 64'(groupIdx), 0);
    checkState("R1");

    // R10 sweep of launch counts; R2 group slices for each
    for (int n = 0; n <= 70; n++) begin
      issue(7, '0, n, "R10 launch");
      for (int c = 0; c < 4; c++) begin
        logic [1:0] g;
        g = groupIdx;
        check(groupMask == mMask[g*16 +: 16], "R2 groupMask", 64'(groupMask), 64'(mMask[g*16 +: 16]));
        @(negedge clk);
        check(groupIdx == 2'(g + 2'd1), "R2 groupIdx step", 64'(groupIdx), 64'(2'(g + 2'd1)));
      end
    end

    // R3 R4 R5 random nesting down to full depth
    for (int trial = 0; trial < 20; trial++) begin
      issue(7, '0, 64 - trial, "R10 relaunch");
      for (int d = 0; d < 8; d++) issue(1, rnd64(), 0, "R3 if");
      for (int d = 0; d < 8; d++) begin
        issue(2, '0, 0, "R4 else");
        issue(3, '0, 0, "R5 endif");
      end
    end

    // R6 an empty then side, full else side
    issue(7, '0, 64, "R10 full");
    issue(1, '0, 0, "R6 empty if");
    issue(2, '0, 0, "R6 else after empty");
    issue(3, '0, 0, "R5 close");
    issue(1, '1, 0, "R6 full if");
    issue(2, '0, 0, "R6 empty else");
    issue(3, '0, 0, "R5 close");

    // R11 idle with a command on the bus but cmdValid low, then op 0
    cmdOp = 3'd1; condBits = '0;
    @(negedge clk);
    checkState("R11 idle");
    issue(0, '0, 0, "R11 nop");

    // R7 loop with per-lane trip counts 0..6
    begin
      int trips [64];
      int passes = 0;
      int longest = 0;
      issue(7, '0, 64, "R7 launch");
      issue(4, '0, 0, "R7 loop open");
      for (int i = 0; i < 64; i++) begin
        trips[i] = i % 7;
        if (trips[i] > longest) longest = trips[i];
      end
      for (int it = 0; it < 20; it++) begin
        logic [63:0] c;
        for (int i = 0; i < 64; i++) c[i] = (it < trips[i]);
        issue(5, c, 0, "R7 loop test");
        if (!loopAgain) break;
        passes++;
      end
      check(passes == longest, "R7 pass count", 64'(passes), 64'(longest));
      issue(6, '0, 0, "R7 loop close");
    end

    // R8 overflow at depth 8
    issue(7, '0, 40, "R10 partial");
    for (int d = 0; d < 8; d++) issue(4, '0, 0, "R8 fill");
    issue(1, rnd64(), 0, "R8 overflow if");
    issue(4, '0, 0, "R8 overflow loop");
    for (int d = 0; d < 8; d++) issue(6, '0, 0, "R8 drain");

    // R9 underflow cases and stickiness across launch
    doReset();
    @(negedge clk);
    issue(3, '0, 0, "R9 empty endif");
    issue(2, rnd64(), 0, "R9 empty else");
    issue(6, '0, 0, "R9 empty loop close");
    issue(7, '0, 12, "R9 sticky launch");
    doReset();
    checkState("R9 cleared by reset");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule